// File: doc/BRIEF.md
# Eight-Level Priority Request Cell Array

This block holds the per-level request state of a small interrupt controller. It has a parameterised row of request cells, eight by default, and a fixed-priority resolver above them. Each cell captures its request line in one of two ways. In edge mode the cell takes a rising edge, and only after it has seen the line low. In level mode the cell simply follows the line. Each cell then passes the request through a latch that a freeze input can hold. The block also keeps a software mask and an in-service bit for every level. Level 0 has the highest priority.

A controller wrapped around this block raises `freeze` during an acknowledge or poll sequence. It pulses `ack` to move the winning request into service and pulses `eoi` to retire the most urgent level in service. It drives `init_clr` while the first initialization word is written. The block computes the interrupt output and the winning level from the stored state and presents both as registered outputs.

Top module: `prc_array`

## Requirements
- R1: After synchronous reset, `req_q`, `isr_q` and `mask_q` are all zero, and `int_out` and `win_lvl` are 0.
- R2: With `level_mode`=1 and `freeze`=0, each `req_q` bit equals its `irq_in` bit as sampled at the previous clock edge. It falls when the input falls.
- R3: With `level_mode`=0, a `req_q` bit is set by a 0-to-1 transition of its input, but only if the input was sampled low at an earlier edge after reset or clear. A line that is already high after a clear does not set the bit. The bit stays set after the input falls.
- R4: While `freeze`=1, `req_q` does not change because of `irq_in`. A rising edge that arrives during the freeze is kept and shows in `req_q` one cycle after `freeze` drops.
- R5: `mask_we`=1 loads `mask_wdata` into `mask_q` at the next edge. The mask never changes `req_q`.
- R6: An `ack` pulse clears the lowest-indexed bit of `req_q & ~mask_q` and sets the same bit of `isr_q`. If no such bit exists, `ack` changes nothing.
- R7: An `eoi` pulse clears the lowest-indexed set bit of `isr_q`.
- R8: `int_out` is registered. It is 1 one cycle after the stored state holds an unmasked request whose index is lower than every set `isr_q` bit. `win_lvl` is the lowest unmasked requesting index, registered the same way, and is 0 when there is none.
- R9: `init_clr` clears `req_q`, `isr_q`, `mask_q` and every cell's edge memory at the next edge. It overrides `mask_we` and `ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | LEVELS | Request lines, bit 0 highest priority |
| level_mode | input | 1 | 1 = level capture, 0 = edge capture |
| freeze | input | 1 | Holds the request latches |
| ack | input | 1 | Acknowledge strobe, one cycle |
| eoi | input | 1 | Non-specific end-of-interrupt, one cycle |
| init_clr | input | 1 | Master clear during initialization |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | LEVELS | Mask value, 1 = masked |
| req_q | output | LEVELS | Request register, raw |
| isr_q | output | LEVELS | In-service register |
| mask_q | output | LEVELS | Mask register |
| int_out | output | 1 | Interrupt output |
| win_lvl | output | clog2(LEVELS) | Winning level index |

## Verification
The three registers are visible at the ports on the edge after each command. So a wrong cell bit, a lost captured edge or a wrong in-service update shows one cycle after the stimulus that caused it. A wrong priority comparison stays hidden inside the block, and appears only as a wrong `int_out` or `win_lvl` one cycle after the stored state changes. For that reason the bench checks every output on every cycle against a cycle model, covering edge capture while frozen, masked acknowledges and nested in-service levels.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int unsigned PRC_LEVELS = 8;
endpackage

// File: rtl/prc_first.sv
module prc_first #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/prc_cell.sv
module prc_cell (
  input  logic clk,
  input  logic rst,
  input  logic irq,
  input  logic level_mode,
  input  logic freeze,
  input  logic ack_hit,
  input  logic init_clr,
  output logic req
);
  logic armed;   // input seen low since last capture or clear
  logic held;    // edge caught while the request latch was frozen
  logic cap;

  assign cap = irq & armed & ~level_mode;

  always_ff @(posedge clk) begin
    if (rst || init_clr) begin
      armed <= 1'b0;
      held  <= 1'b0;
      req   <= 1'b0;
    end else begin
      armed <= ~irq;
      if (freeze || ack_hit) held <= held | cap;
      else                   held <= 1'b0;
      if (ack_hit)           req <= 1'b0;
      else if (!freeze)      req <= level_mode ? irq : (req | held | cap);
    end
  end
endmodule

// File: rtl/prc_array.sv
module prc_array #(
  parameter int unsigned LEVELS = prc_pkg::PRC_LEVELS,
  localparam int unsigned LW = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEVELS-1:0] irq_in,
  input  logic              level_mode,
  input  logic              freeze,
  input  logic              ack,
  input  logic              eoi,
  input  logic              init_clr,
  input  logic              mask_we,
  input  logic [LEVELS-1:0] mask_wdata,
  output logic [LEVELS-1:0] req_q,
  output logic [LEVELS-1:0] isr_q,
  output logic [LEVELS-1:0] mask_q,
  output logic              int_out,
  output logic [LW-1:0]     win_lvl
);
  logic [LEVELS-1:0] eligible, ack_oh, eoi_oh;
  logic              win_found, isr_found, int_next;
  logic [LW-1:0]     win_idx, isr_idx;

  assign eligible = req_q & ~mask_q;

  prc_first #(.N(LEVELS)) u_win (.vec(eligible), .found(win_found), .idx(win_idx));
  prc_first #(.N(LEVELS)) u_srv (.vec(isr_q),    .found(isr_found), .idx(isr_idx));

  assign ack_oh   = (ack && win_found) ? (LEVELS'(1) << win_idx) : '0;
  assign eoi_oh   = (eoi && isr_found) ? (LEVELS'(1) << isr_idx) : '0;
  assign int_next = win_found && (!isr_found || (win_idx < isr_idx));

  for (genvar g = 0; g < LEVELS; g++) begin : g_cell
    prc_cell u_cell (
      .clk        (clk),
      .rst        (rst),
      .irq        (irq_in[g]),
      .level_mode (level_mode),
      .freeze     (freeze),
      .ack_hit    (ack_oh[g]),
      .init_clr   (init_clr),
      .req        (req_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || init_clr) begin
      isr_q  <= '0;
      mask_q <= '0;
    end else begin
      isr_q <= (isr_q | ack_oh) & ~eoi_oh;
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_out <= 1'b0;
      win_lvl <= '0;
    end else begin
      int_out <= int_next;
      win_lvl <= win_found ? win_idx : '0;
    end
  end
endmodule

// File: rtl/prc_array_chk.sv
module prc_array_chk #(
  parameter int unsigned LEVELS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              freeze,
  input logic              ack,
  input logic              eoi,
  input logic              init_clr,
  input logic              mask_we,
  input logic [LEVELS-1:0] mask_wdata,
  input logic [LEVELS-1:0] req_q,
  input logic [LEVELS-1:0] isr_q,
  input logic [LEVELS-1:0] mask_q
);
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    init_clr |=> (req_q == '0 && isr_q == '0 && mask_q == '0)); // R9

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (freeze && !ack && !init_clr) |=> (req_q == $past(req_q))); // R4

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (rst)
    (mask_we && !init_clr) |=> (mask_q == $past(mask_wdata))); // R5

  AST_ACK_ADDS_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (ack && !eoi && !init_clr && ((req_q & ~mask_q) != '0))
      |=> ((isr_q & ~$past(isr_q)) != '0)); // R6

  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
    (eoi && !ack && !init_clr && (isr_q != '0))
      |=> ($countones(isr_q) + 1 == $countones($past(isr_q)))); // R7
endmodule

bind prc_array prc_array_chk #(.LEVELS(LEVELS)) u_chk (.*);

// File: tb/sim_prc_array.sv
module sim_prc_array;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic         level_mode = 1'b0, freeze = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic         init_clr = 1'b0, mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic [N-1:0] req_q, isr_q, mask_q;
  logic         int_out;
  logic [2:0]   win_lvl;

  always #2 clk = ~clk;

  prc_array #(.LEVELS(N)) u0 (.*);

  typedef struct {
    string      tag;
    logic [7:0] req, isr, mask;
    logic       intr;
    logic [2:0] lvl;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   done = 0;

  // reference state, derived from the requirements
  logic [7:0] m_req = '0, m_isr = '0, m_mask = '0, m_arm = '0, m_held = '0;

  function automatic int first_set(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic step(string tag, logic [7:0] irq, logic lm, logic fz,
                      logic ak, logic eo, logic ic, logic mw, logic [7:0] md);
    exp_t e;
    int w, s;
    logic [7:0] ackv, eov, n_req, n_arm, n_held;
    @(negedge clk);
    irq_in = irq; level_mode = lm; freeze = fz; ack = ak; eoi = eo;
    init_clr = ic; mask_we = mw; mask_wdata = md;
    w = first_set(m_req & ~m_mask);
    s = first_set(m_isr);
    e.tag  = tag;
    e.intr = (w < 8) && (w < s);
    e.lvl  = (w < 8) ? 3'(w) : 3'd0;
    ackv = (ak && w < 8) ? (8'd1 << w) : 8'd0;
    eov  = (eo && s < 8) ? (8'd1 << s) : 8'd0;
    if (ic) begin
      m_req = '0; m_isr = '0; m_mask = '0; m_arm = '0; m_held = '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        logic cap;
        cap = irq[i] & m_arm[i] & ~lm;
        n_arm[i]  = ~irq[i];
        n_held[i] = (fz || ackv[i]) ? (m_held[i] | cap) : 1'b0;
        if (ackv[i])  n_req[i] = 1'b0;
        else if (!fz) n_req[i] = lm ? irq[i] : (m_req[i] | m_held[i] | cap);
        else          n_req[i] = m_req[i];
      end
      m_req = n_req; m_arm = n_arm; m_held = n_held;
      m_isr = (m_isr | ackv) & ~eov;
      if (mw) m_mask = md;
    end
    e.req = m_req; e.isr = m_isr; e.mask = m_mask;
    q.push_back(e);
  endtask

  // monitor: compares one expected item per clock edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (req_q !== e.req || isr_q !== e.isr || mask_q !== e.mask ||
          int_out !== e.intr || win_lvl !== e.lvl) begin
        errors++;
        $display("FAIL %s: req=%h isr=%h mask=%h int=%b lvl=%0d expected req=%h isr=%h mask=%h int=%b lvl=%0d",
                 e.tag, req_q, isr_q, mask_q, int_out, win_lvl,
                 e.req, e.isr, e.mask, e.intr, e.lvl);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    step("R1", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R1", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    // R3 edge capture on level 3, kept after the line falls
    step("R3", 8'h08, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R3", 8'h08, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R8", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R3", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    // R5 mask hides it from the interrupt, not from req_q
    step("R5", 8'h00, 0, 0, 0, 0, 0, 1, 8'h08);
    step("R5", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R8", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    // R6 masked-only request: ack does nothing
    step("R6", 8'h00, 0, 1, 1, 0, 0, 0, 8'h00);
    step("R5", 8'h00, 0, 0, 0, 0, 0, 1, 8'h00);
    step("R8", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    // R6 acknowledge level 3 under freeze
    step("R6", 8'h00, 0, 1, 1, 0, 0, 0, 8'h00);
    step("R6", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    // R8 lower priority than in-service: no interrupt
    step("R8", 8'h20, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R8", 8'h20, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R8", 8'h20, 0, 0, 0, 0, 0, 0, 8'h00);
    // R8 higher priority nests
    step("R8", 8'h22, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R8", 8'h22, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R8", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    // R4 edge on level 6 during freeze is held back, then appears
    step("R4", 8'h00, 0, 1, 0, 0, 0, 0, 8'h00);
    step("R4", 8'h40, 0, 1, 0, 0, 0, 0, 8'h00);
    step("R4", 8'h40, 0, 1, 0, 0, 0, 0, 8'h00);
    step("R4", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R4", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    // R6 acknowledge level 1, then R7 retire 1 then 3
    step("R6", 8'h00, 0, 1, 1, 0, 0, 0, 8'h00);
    step("R6", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R7", 8'h00, 0, 0, 0, 1, 0, 0, 8'h00);
    step("R8", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R7", 8'h00, 0, 0, 0, 1, 0, 0, 8'h00);
    step("R8", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R7", 8'h00, 0, 0, 0, 1, 0, 0, 8'h00);
    // R9 clear with line 2 high and a mask write pending
    step("R9", 8'h04, 0, 0, 1, 0, 1, 1, 8'hFF);
    step("R3", 8'h04, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R3", 8'h04, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R3", 8'h00, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R3", 8'h04, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R8", 8'h04, 0, 0, 0, 0, 0, 0, 8'h00);
    step("R9", 8'h00, 0, 0, 0, 0, 1, 0, 8'h00);
    // R2 level mode follows the line both ways
    step("R2", 8'h80, 1, 0, 0, 0, 0, 0, 8'h00);
    step("R2", 8'h81, 1, 0, 0, 0, 0, 0, 8'h00);
    step("R8", 8'h80, 1, 0, 0, 0, 0, 0, 8'h00);
    step("R2", 8'h00, 1, 0, 0, 0, 0, 0, 8'h00);
    step("R4", 8'hF0, 1, 1, 0, 0, 0, 0, 8'h00);
    step("R2", 8'hF0, 1, 0, 0, 0, 0, 0, 8'h00);
    step("R8", 8'h00, 1, 0, 0, 0, 0, 0, 8'h00);
    step("R2", 8'h00, 1, 0, 0, 0, 0, 0, 8'h00);
    @(posedge clk);
    @(posedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule